// File: doc/BRIEF.md
# Synchronous Burst Flash Read Front End

This block is the read side of a burst-capable NOR-style flash model. A host addresses it with a chip-select, an output-enable, a latch-enable strobe and an address bus. It reads back 16-bit words from a small internal array. In asynchronous mode the address passes through a latch that follows the bus while the latch strobe is low and freezes when the strobe goes high. The selected word is then presented on the data bus. In synchronous mode the address is taken on an edge of the host clock. The active edge, rising or falling, is chosen by a configuration bit. After a programmable first-access latency the block streams consecutive words, one per active clock edge. A WAIT output tells the host which edges carry valid data.

All host pins are sampled by one internal system clock. The host clock is treated as a data input and its edges are found by comparing it with its previous sample. A configuration register is loaded from the low address bits through a dedicated write strobe. It chooses the mode, the active clock edge, the WAIT timing, the latency and the burst length. Program and erase are not part of this block.

Top module: `fbr_read_if`

## Requirements
- R1: While `le_n` is low the address latch follows `addr` on each system clock edge. While `le_n` is high it keeps the last value captured while it was low.
- R2: In asynchronous mode `dq_out` shows the array word at the latched address one system clock after capture. The word at index i is the low 16 bits of i*40503 XOR 16'hA5C3.
- R3: `dq_oe` and `wait_oe` are both 0 whenever `ce_n` is high, `oe_n` is high or `rst_n` is low.
- R4: Reset clears the configuration register to 8'h00, which selects asynchronous mode. After reset `dq_oe` stays 0 until a falling edge of `ce_n` or of `le_n` is seen while reset is released.
- R5: A cycle with `cfg_wr` high and `ce_n` low loads the configuration from `addr[7:0]`. The fields are: [7] sync mode (1 = synchronous), [6] early WAIT, [5] active edge (1 = rising, 0 = falling), [4:3] burst length, [2:0] latency. Host clock edges are ignored during a `cfg_wr` cycle and in asynchronous mode.
- R6: In synchronous mode an active host clock edge seen while `le_n` is low starts a burst at the current `addr`.
- R7: After the start edge, WAIT (active high) stays asserted until the L-th active edge. From then on the word at the start address is valid. L is the latency field, and codes 0 and 1 act as 2.
- R8: Once the first word is valid, each further active edge with `le_n` high moves to the next linear address.
- R9: Burst length codes are 0 = 4, 1 = 8, 2 = 16 and 3 = continuous. After a fixed burst has delivered its last word, the next active edge asserts WAIT and `dq_out` holds the last word.
- R10: A continuous burst wraps from the last array address to address 0.
- R11: With early WAIT set, WAIT changes one active edge ahead. It deasserts on the edge before the first valid word and asserts while the last word of a fixed burst is shown.
- R12: Raising `ce_n` aborts a burst. With `ce_n` low again WAIT stays asserted until a new start edge, even when host clock edges arrive with `le_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all host pins |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| le_n | input | 1 | Active-low address latch enable |
| kclk | input | 1 | Host burst clock, sampled as data |
| cfg_wr | input | 1 | Configuration write strobe, value from addr[7:0] |
| addr | input | AW | Address bus |
| dq_out | output | DW | Read data |
| dq_oe | output | 1 | Drive enable for dq_out (0 = high impedance) |
| wait_o | output | 1 | WAIT, high means data not valid |
| wait_oe | output | 1 | Drive enable for wait_o (0 = high impedance) |

## Verification
The hardest conditions to reach are the boundaries of a burst: the edge where latency ends, the last word of a fixed burst, and the wrap at the top of the array. In early-WAIT mode these shift by one edge. The bench builds bursts with random latency, length, edge sense, WAIT timing and start address. It runs each burst past its end and compares every edge with a model built from edge counts. Directed cases add a continuous burst that starts two words below the array top, a configuration write that carries a host clock toggle in the middle of a burst, and an abort followed by clock edges with no new address.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

   typedef struct packed {
      logic       sync_en;
      logic       wait_early;
      logic       edge_rise;
      logic [1:0] blen;
      logic [2:0] lat;
   } fbr_cfg_t;

   localparam int unsigned CFG_W = $bits(fbr_cfg_t);

   function automatic logic [2:0] eff_latency(input logic [2:0] code);
      return (code < 3'd2) ? 3'd2 : code;
   endfunction

   function automatic logic [3:0] burst_last(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd3;
         2'd1:    return 4'd7;
         default: return 4'd15;
      endcase
   endfunction

   function automatic logic is_continuous(input logic [1:0] code);
      return code == 2'd3;
   endfunction

endpackage

// File: rtl/fbr_array.sv
module fbr_array #(
   parameter int unsigned AW   = 8,
   parameter int unsigned DW   = 16,
   parameter int unsigned SEED = 32'h0000_A5C3,
   parameter int unsigned MULT = 40503
) (
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      localparam int unsigned PROD = i * MULT;
      localparam logic [31:0] PV   = PROD;
      localparam logic [31:0] SV   = SEED;
      assign words[i] = PV[DW-1:0] ^ SV[DW-1:0];
   end

   assign rdata = words[raddr];
endmodule

// File: rtl/fbr_front.sv
module fbr_front #(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          le_n,
   input  logic          kclk,
   input  logic          cfg_wr,
   input  logic          sync_en,
   input  logic          edge_rise,
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] addr_q,
   output logic          armed,
   output logic          kedge
);
   logic k_prev, ce_prev_n, le_prev_n;
   logic k_rise, k_fall, ce_fall, le_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_prev    <= 1'b0;
         ce_prev_n <= 1'b0;
         le_prev_n <= 1'b0;
      end else begin
         k_prev    <= kclk;
         ce_prev_n <= ce_n;
         le_prev_n <= le_n;
      end
   end

   assign k_rise  = kclk & ~k_prev;
   assign k_fall  = ~kclk & k_prev;
   assign ce_fall = ce_prev_n & ~ce_n;
   assign le_fall = le_prev_n & ~le_n;

   // transparent-while-low address latch, sampled by the system clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (!le_n)  addr_q <= addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  armed <= 1'b0;
      else if (ce_fall || le_fall) armed <= 1'b1;
   end

   assign kedge = sync_en & ~cfg_wr & ~ce_n & (edge_rise ? k_rise : k_fall);
endmodule

// File: rtl/fbr_burst_seq.sv
module fbr_burst_seq
   import fbr_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          le_n,
   input  logic          kedge,
   input  fbr_cfg_t      cfg,
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] bptr,
   output logic          wait_raw,
   output logic          active,
   output logic          done,
   output logic          start,
   output logic          adv,
   output logic [2:0]    wcnt
);
   logic [3:0] beat;
   logic [2:0] lat_eff;
   logic [3:0] last_beat;
   logic       cont;
   logic       tick;
   logic       at_last;

   assign lat_eff   = eff_latency(cfg.lat);
   assign last_beat = burst_last(cfg.blen);
   assign cont      = is_continuous(cfg.blen);

   assign start   = kedge & ~le_n;
   assign tick    = kedge & le_n & active;
   assign at_last = ~cont & (beat == last_beat);
   assign adv     = tick & (wcnt == 3'd0) & ~done & ~at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         done   <= 1'b0;
         wcnt   <= 3'd0;
         beat   <= 4'd0;
         bptr   <= '0;
      end else if (ce_n || !cfg.sync_en) begin
         active <= 1'b0;
         done   <= 1'b0;
      end else if (start) begin
         active <= 1'b1;
         done   <= 1'b0;
         wcnt   <= lat_eff;
         beat   <= 4'd0;
         bptr   <= addr;
      end else if (tick) begin
         if (wcnt != 3'd0) begin
            wcnt <= wcnt - 3'd1;
         end else if (!done) begin
            if (at_last) begin
               done <= 1'b1;
            end else begin
               bptr <= bptr + 1'b1;
               beat <= beat + 4'd1;
            end
         end
      end
   end

   logic wait_norm, wait_adv;
   assign wait_norm = ~active | (wcnt != 3'd0) | done;
   assign wait_adv  = ~active | (wcnt > 3'd1) | done | ((wcnt == 3'd0) & at_last);
   assign wait_raw  = cfg.wait_early ? wait_adv : wait_norm;
endmodule

// File: rtl/fbr_read_if.sv
module fbr_read_if
   import fbr_pkg::*;
#(
   parameter int unsigned AW   = 8,
   parameter int unsigned DW   = 16,
   parameter int unsigned SEED = 32'h0000_A5C3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          le_n,
   input  logic          kclk,
   input  logic          cfg_wr,
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] dq_out,
   output logic          dq_oe,
   output logic          wait_o,
   output logic          wait_oe
);
   if (AW < CFG_W || AW > 12) begin : g_bad_aw
      $error("fbr_read_if: AW must be between CFG_W and 12");
   end
   if (DW < 8 || DW > 32) begin : g_bad_dw
      $error("fbr_read_if: DW must be between 8 and 32");
   end

   fbr_cfg_t      cfg;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] bptr;
   logic [AW-1:0] rd_addr;
   logic          armed, kedge;
   logic          wait_raw, seq_active, seq_done, seq_start, seq_adv;
   logic [2:0]    seq_wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cfg <= '0;
      else if (cfg_wr && !ce_n)  cfg <= fbr_cfg_t'(addr[CFG_W-1:0]);
   end

   fbr_front #(.AW(AW)) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .le_n      (le_n),
      .kclk      (kclk),
      .cfg_wr    (cfg_wr),
      .sync_en   (cfg.sync_en),
      .edge_rise (cfg.edge_rise),
      .addr      (addr),
      .addr_q    (addr_q),
      .armed     (armed),
      .kedge     (kedge)
   );

   fbr_burst_seq #(.AW(AW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .le_n     (le_n),
      .kedge    (kedge),
      .cfg      (cfg),
      .addr     (addr),
      .bptr     (bptr),
      .wait_raw (wait_raw),
      .active   (seq_active),
      .done     (seq_done),
      .start    (seq_start),
      .adv      (seq_adv),
      .wcnt     (seq_wcnt)
   );

   assign rd_addr = cfg.sync_en ? bptr : addr_q;

   fbr_array #(.AW(AW), .DW(DW), .SEED(SEED)) u_array (
      .raddr (rd_addr),
      .rdata (dq_out)
   );

   logic drive_ok;
   assign drive_ok = rst_n & ~ce_n & ~oe_n;
   assign dq_oe    = drive_ok & armed;
   assign wait_oe  = drive_ok;
   assign wait_o   = cfg.sync_en & wait_raw;
endmodule

// File: rtl/fbr_read_if_chk.sv
module fbr_read_if_chk #(
   parameter int unsigned AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_n,
   input logic          oe_n,
   input logic          le_n,
   input logic          cfg_wr,
   input logic          dq_oe,
   input logic          wait_oe,
   input logic          wait_o,
   input logic          armed,
   input logic          sync_en,
   input logic          wait_early,
   input logic          start,
   input logic          adv,
   input logic          active,
   input logic          done,
   input logic [2:0]    wcnt,
   input logic [AW-1:0] bptr
);
   // R3
   hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> (!dq_oe && !wait_oe));

   // R4
   arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !dq_oe);

   // R7
   lat_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (wait_o || !sync_en));

   // R8
   inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (bptr == $past(bptr) + 1'b1));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && le_n) |=> $stable(bptr));

   // R5
   wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> $stable(bptr));

   // R11
   early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_en && wait_early && active && !done && wcnt == 3'd1) |-> !wait_o);
endmodule

bind fbr_read_if fbr_read_if_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .oe_n       (oe_n),
   .le_n       (le_n),
   .cfg_wr     (cfg_wr),
   .dq_oe      (dq_oe),
   .wait_oe    (wait_oe),
   .wait_o     (wait_o),
   .armed      (armed),
   .sync_en    (cfg.sync_en),
   .wait_early (cfg.wait_early),
   .start      (seq_start),
   .adv        (seq_adv),
   .active     (seq_active),
   .done       (seq_done),
   .wcnt       (seq_wcnt),
   .bptr       (bptr)
);

// File: tb/sim_fbr_read_if.sv
`timescale 1ns/1ps
module sim_fbr_read_if;
   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n, ce_n, oe_n, le_n, kclk, cfg_wr;
   logic [AW-1:0] addr;
   logic [DW-1:0] dq_out;
   logic          dq_oe, wait_o, wait_oe;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic idle_k = 1'b0;

   always #2.5 clk = ~clk;

   fbr_read_if #(.AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .le_n(le_n),
      .kclk(kclk), .cfg_wr(cfg_wr), .addr(addr), .dq_out(dq_out),
      .dq_oe(dq_oe), .wait_o(wait_o), .wait_oe(wait_oe)
   );

   function automatic logic [15:0] word_at(input int i);
      logic [31:0] p;
      p = (i & 255) * 40503;
      return p[15:0] ^ 16'hA5C3;
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic cfg_write(input logic [7:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; addr = v;
      idle_k = v[5] ? 1'b0 : 1'b1;
      kclk = idle_k;
      cyc();
      @(negedge clk); cfg_wr = 1'b0;
      cyc();
   endtask

   task automatic kpulse();
      @(negedge clk); kclk = ~idle_k;
      @(posedge clk);
      @(negedge clk); kclk = idle_k;
      cyc();
   endtask

   task automatic run_burst(input logic [2:0] lat, input logic [1:0] bl, input bit er,
                            input bit early, input int a, input int extra);
      int l, n, kmax;
      bit cont;
      logic [15:0] e_dq;
      logic e_w;
      l = (lat < 2) ? 2 : int'(lat);
      cont = (bl == 2'd3);
      n = 4 << bl;
      cfg_write({1'b1, early, er, bl, lat});
      @(negedge clk); le_n = 1'b0; addr = a[AW-1:0];
      kpulse();
      @(negedge clk); le_n = 1'b1; addr = '0;
      #1;
      chk("R6 start", {31'd0, wait_o}, 32'd1);
      kmax = l + (cont ? 20 : n) + extra;
      for (int k = 1; k <= kmax; k++) begin
         kpulse();
         if (k < l) begin
            e_w = early ? ((l - k) >= 2) : 1'b1;
            chk("R7 latency wait", {31'd0, wait_o}, {31'd0, e_w});
         end else begin
            int j;
            j = k - l;
            if (cont) begin
               e_dq = word_at(a + j);
               e_w = 1'b0;
               chk("R10 continuous data", {16'd0, dq_out}, {16'd0, e_dq});
            end else if (j < n) begin
               e_dq = word_at(a + j);
               e_w = early ? (j == n - 1) : 1'b0;
               chk("R8 linear data", {16'd0, dq_out}, {16'd0, e_dq});
            end else begin
               e_dq = word_at(a + n - 1);
               e_w = 1'b1;
               chk("R9 end hold data", {16'd0, dq_out}, {16'd0, e_dq});
            end
            chk(early ? "R11 early wait" : "R9 data wait", {31'd0, wait_o}, {31'd0, e_w});
         end
      end
   endtask

   initial begin
      rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; le_n = 1'b0;
      kclk = 1'b0; cfg_wr = 1'b0; addr = '0;
      void'($urandom(32'd20240611));
      repeat (3) cyc();
      chk("R3 reset dq_oe", {31'd0, dq_oe}, 32'd0);
      chk("R3 reset wait_oe", {31'd0, wait_oe}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      cyc(); cyc();
      chk("R4 no drive before edge", {31'd0, dq_oe}, 32'd0);
      chk("R4 async after reset", {31'd0, wait_o}, 32'd0);
      // a host clock edge after reset must not start a burst (async mode)
      @(negedge clk); addr = 8'h21;
      kpulse();
      @(negedge clk); le_n = 1'b1; addr = 8'h99;
      cyc();
      @(negedge clk); le_n = 1'b0; addr = 8'h37;
      cyc();
      chk("R4 armed by le fall", {31'd0, dq_oe}, 32'd1);
      chk("R2 async read", {16'd0, dq_out}, {16'd0, word_at(8'h37)});
      @(negedge clk); le_n = 1'b1; addr = 8'hC4;
      cyc(); cyc();
      chk("R1 latch holds", {16'd0, dq_out}, {16'd0, word_at(8'h37)});
      kpulse();
      chk("R5 async ignores kclk", {16'd0, dq_out}, {16'd0, word_at(8'h37)});
      @(negedge clk); oe_n = 1'b1;
      #1;
      chk("R3 oe high", {30'd0, dq_oe, wait_oe}, 32'd0);
      @(negedge clk); oe_n = 1'b0;
      // random asynchronous reads
      for (int i = 0; i < 10; i++) begin
         int a;
         a = $urandom_range(0, 255);
         @(negedge clk); le_n = 1'b0; addr = a[AW-1:0];
         cyc();
         @(negedge clk); le_n = 1'b1; addr = ~a[AW-1:0];
         cyc();
         chk("R1 R2 random async", {16'd0, dq_out}, {16'd0, word_at(a)});
      end
      // directed bursts
      run_burst(3'd0, 2'd0, 1'b1, 1'b0, 8'h10, 2);
      run_burst(3'd4, 2'd1, 1'b0, 1'b1, 8'h40, 2);
      run_burst(3'd2, 2'd3, 1'b1, 1'b0, 254, 0);
      run_burst(3'd7, 2'd2, 1'b0, 1'b0, 8'hF8, 1);
      // random bursts
      for (int i = 0; i < 14; i++) begin
         run_burst(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   $urandom_range(0, 255), $urandom_range(0, 3));
      end
      // clock toggle during a configuration write is ignored mid-burst
      cfg_write({1'b1, 1'b0, 1'b1, 2'd3, 3'd2});
      @(negedge clk); le_n = 1'b0; addr = 8'h80;
      kpulse();
      @(negedge clk); le_n = 1'b1;
      kpulse(); kpulse(); kpulse();
      chk("R8 pre write", {16'd0, dq_out}, {16'd0, word_at(8'h81)});
      @(negedge clk); cfg_wr = 1'b1; addr = {1'b1, 1'b0, 1'b1, 2'd3, 3'd2}; kclk = 1'b1;
      cyc();
      @(negedge clk); cfg_wr = 1'b0;
      @(negedge clk); kclk = 1'b0;
      cyc();
      chk("R5 kclk ignored in write", {16'd0, dq_out}, {16'd0, word_at(8'h81)});
      // abort with ce_n
      @(negedge clk); ce_n = 1'b1;
      #1;
      chk("R3 ce high", {30'd0, dq_oe, wait_oe}, 32'd0);
      cyc();
      @(negedge clk); ce_n = 1'b0;
      cyc();
      chk("R12 wait after abort", {31'd0, wait_o}, 32'd1);
      kpulse(); kpulse();
      chk("R12 no restart without address", {31'd0, wait_o}, 32'd1);
      chk("R12 driven again", {31'd0, dq_oe}, 32'd1);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule